// File: doc/BRIEF.md
# Sixteen-Bit Compare/Capture Timer with PWM and Single-Pulse Output

This block is a 16-bit up-counter with two compare channels, two input-capture channels, a PWM mode and a single-pulse mode. The counter is clocked from a divided system clock or from an edge of an external clock pin. Compare matches set sticky flags and drive two compare pins. Capture-pin edges snapshot the counter into per-channel capture registers. An 8-bit control register and a small auxiliary register configure the block. The auxiliary register holds the capture-1 edge select and the two output levels.

Software reaches the block through a single-cycle register port: a write strobe, a read strobe, a shared 3-bit address and 16-bit write data. Read data is combinational from the address. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. A read or write completes in the cycle its strobe is high. Compare pins, flags and capture/clock pins are plain level signals. All three asynchronous pins are resynchronised inside the block.

Register map (address: content): 0 control, 1 compare 1, 2 compare 2, 3 capture 1 (read-only), 4 capture 2 (read-only), 5 counter (read-only), 6 auxiliary. Address 7 reads zero.

Top module: `ctimer_top`

## Requirements
- R1: After reset, the control register, the auxiliary register, the counter, both compare registers, both capture registers and all four flags are zero, and both compare pins are low.
- R2: Control bits 3:2 select the counting rate. Code 00 advances the counter once every 4 system clocks, 01 once every 2, and 10 once every 8.
- R3: Code 11 advances the counter once per selected edge of the external clock pin, at most once per system clock, after a two-flop synchroniser. Control bit 0 selects the edge: 1 means rising, 0 means falling.
- R4: When the block is built without an external clock pin (HAS_EXT_CLK = 0), code 11 freezes the counter.
- R5: A selected edge on a capture pin copies the counter into that channel's capture register and sets its capture flag (cap_flag_o bit 0 for pin 1, bit 1 for pin 2). Control bit 1 selects the edge for pin 2, and auxiliary bit 0 selects it for pin 1. In both cases 1 means rising and 0 means falling. The other edge has no effect.
- R6: Reading a capture register clears that channel's capture flag. A capture in the same cycle as the read leaves the flag set.
- R7: In output-compare mode, a counter step onto the value of compare 1 sets cmp_flag_o bit 0 and latches auxiliary bit 1 (level 1) as the pin-1 level. A step onto compare 2 sets cmp_flag_o bit 1 and latches auxiliary bit 2 (level 2) as the pin-2 level. Writing a compare register clears its flag.
- R8: Control bit 7 enables oc1_o and bit 6 enables oc2_o. A disabled pin drives low. Matching, flagging and the latched level continue regardless.
- R9: Control bit 4 selects PWM. A counter step taken while the count is at or above compare 2 reloads it to zero. oc1_o carries level 1 while the count is below compare 1, and level 2 otherwise. PWM takes priority over the single-pulse mode.
- R10: Control bit 5 (with bit 4 clear) selects single-pulse mode. A selected edge on capture pin 1 resets the counter to zero and drives level 1 on oc1_o. Level 2 returns when the counter steps onto compare 1. Between pulses, oc1_o carries level 2.
- R11: In single-pulse mode, a trigger edge during an active pulse is ignored and does not restart the count.
- R12: The register addresses are fixed as listed above, and writes to the read-only addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_i | input | 1 | External counter clock pin (asynchronous) |
| cap1_i | input | 1 | Capture pin 1, also the single-pulse trigger (asynchronous) |
| cap2_i | input | 1 | Capture pin 2 (asynchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears a capture flag when reading a capture register) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |
| oc1_o | output | 1 | Compare pin 1 |
| oc2_o | output | 1 | Compare pin 2 |
| cmp_flag_o | output | 2 | Sticky compare flags, bit 0 for compare 1 |
| cap_flag_o | output | 2 | Sticky capture flags, bit 0 for capture pin 1 |

## Verification
The bench builds two copies of the block that share every input. One uses the default HAS_EXT_CLK = 1 and the other uses HAS_EXT_CLK = 0, so the frozen-counter case with no external clock pin is observable on the same external-clock stimulus. The 16-bit default width is kept. In external-clock mode the bench owns every counter step, which makes compare matches, PWM reload points, pulse ends and retrigger rejection land on exactly computed counts. The divided-clock rates are checked as counter deltas over an 80-cycle window, a multiple of every divisor.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;

  localparam int unsigned CT_W = 16;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_CMP1 = 3'd1,
    A_CMP2 = 3'd2,
    A_CAP1 = 3'd3,
    A_CAP2 = 3'd4,
    A_CNT  = 3'd5,
    A_AUX  = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    CK_DIV4 = 2'b00,
    CK_DIV2 = 2'b01,
    CK_DIV8 = 2'b10,
    CK_EXT  = 2'b11
  } clk_sel_e;

  // Control register, bit 7 first
  typedef struct packed {
    logic     pin1_en;
    logic     pin2_en;
    logic     one_pulse;
    logic     pwm;
    clk_sel_e clk_sel;
    logic     cap2_rise;
    logic     ext_rise;
  } ctrl_t;

endpackage

// File: rtl/ctimer_edge.sv
module ctimer_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  output logic edge_o
);
  // [0],[1]: synchroniser, [2]: previous synchronised value
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], din};
  end

  assign edge_o = rise_sel ? (sh[1] & ~sh[2]) : (~sh[1] & sh[2]);

endmodule

// File: rtl/ctimer_prescale.sv
module ctimer_prescale
  import ctimer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e sel,
  input  logic     ext_tick,
  output logic     tick
);
  localparam int unsigned MAX_DIV = 8;
  localparam int unsigned DW = $clog2(MAX_DIV);

  logic [DW-1:0] div;

  always_ff @(posedge clk) begin
    if (!rst_n) div <= '0;
    else        div <= div + 1'b1;
  end

  always_comb begin
    unique case (sel)
      CK_DIV4: tick = &div[1:0];
      CK_DIV2: tick = div[0];
      CK_DIV8: tick = &div;
      default: tick = ext_tick;
    endcase
  end

  // after any divided tick the divider's low bits are zero: no divided tick next cycle
  assert_div_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != CK_EXT) |=> !(tick && sel != CK_EXT));

endmodule

// File: rtl/ctimer_capture.sv
module ctimer_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic         rd_clr,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] val,
  output logic         flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val  <= '0;
      flag <= 1'b0;
    end else if (hit) begin
      val  <= cnt;
      flag <= 1'b1;
    end else if (rd_clr) begin
      flag <= 1'b0;
    end
  end

  assert_capture_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (flag && val == $past(cnt)));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !hit) |=> !flag);

endmodule

// File: rtl/ctimer_top.sv
module ctimer_top
  import ctimer_pkg::*;
#(
  parameter bit          HAS_EXT_CLK = 1'b1,
  parameter int unsigned W           = CT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_clk_i,
  input  logic         cap1_i,
  input  logic         cap2_i,
  input  logic         reg_wr_i,
  input  logic         reg_rd_i,
  input  logic [2:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         oc1_o,
  output logic         oc2_o,
  output logic [1:0]   cmp_flag_o,
  output logic [1:0]   cap_flag_o
);
  localparam int unsigned NPIN = 3;   // ext, cap1, cap2
  localparam int unsigned NCAP = 2;
  localparam int unsigned CW   = $bits(ctrl_t);
  localparam int unsigned AW   = 3;

  ctrl_t          ctrl;
  logic [AW-1:0]  aux;       // [0] cap1 rising, [1] level 1, [2] level 2
  logic [W-1:0]   cmp1, cmp2, cnt, cnt_d;
  logic           oc1_q, oc2_q, os_active;
  logic [1:0]     cflag;

  // ---------------- pin synchronisers ----------------
  logic [NPIN-1:0] pin_in, pin_rise, pin_edge;
  assign pin_in   = {cap2_i, cap1_i, ext_clk_i};
  assign pin_rise = {ctrl.cap2_rise, aux[0], ctrl.ext_rise};

  for (genvar g = 0; g < NPIN; g++) begin : g_edge
    ctimer_edge u_edge (
      .clk(clk), .rst_n(rst_n), .din(pin_in[g]),
      .rise_sel(pin_rise[g]), .edge_o(pin_edge[g])
    );
  end

  logic ext_tick, tick;
  if (HAS_EXT_CLK) begin : g_ext
    assign ext_tick = pin_edge[0];
  end else begin : g_noext
    assign ext_tick = 1'b0;
  end

  ctimer_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .sel(ctrl.clk_sel),
    .ext_tick(ext_tick), .tick(tick)
  );

  // ---------------- capture channels ----------------
  logic [NCAP-1:0] cap_hit, cap_clr, cap_flag;
  logic [W-1:0]    cap_val [NCAP];
  assign cap_hit = pin_edge[2:1];
  assign cap_clr = {reg_rd_i && reg_addr_i == A_CAP2, reg_rd_i && reg_addr_i == A_CAP1};

  for (genvar c = 0; c < NCAP; c++) begin : g_cap
    ctimer_capture #(.W(W)) u_cap (
      .clk(clk), .rst_n(rst_n), .hit(cap_hit[c]), .rd_clr(cap_clr[c]),
      .cnt(cnt), .val(cap_val[c]), .flag(cap_flag[c])
    );
  end

  // ---------------- counter and modes ----------------
  logic pwm_on, opm_on, trig, hit1, hit2;
  assign pwm_on = ctrl.pwm;
  assign opm_on = ctrl.one_pulse && !ctrl.pwm;
  assign trig   = opm_on && cap_hit[0] && !os_active;

  always_comb begin
    if (trig)                      cnt_d = '0;
    else if (!tick)                cnt_d = cnt;
    else if (pwm_on && cnt >= cmp2) cnt_d = '0;
    else                           cnt_d = cnt + 1'b1;
  end

  assign hit1 = tick && !trig && (cnt_d == cmp1);
  assign hit2 = tick && !trig && (cnt_d == cmp2);

  logic wr_cmp1, wr_cmp2;
  assign wr_cmp1 = reg_wr_i && reg_addr_i == A_CMP1;
  assign wr_cmp2 = reg_wr_i && reg_addr_i == A_CMP2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      aux       <= '0;
      cmp1      <= '0;
      cmp2      <= '0;
      cnt       <= '0;
      oc1_q     <= 1'b0;
      oc2_q     <= 1'b0;
      os_active <= 1'b0;
      cflag     <= '0;
    end else begin
      cnt <= cnt_d;
      if (reg_wr_i && reg_addr_i == A_CTRL) ctrl <= ctrl_t'(reg_wdata_i[CW-1:0]);
      if (reg_wr_i && reg_addr_i == A_AUX)  aux  <= reg_wdata_i[AW-1:0];
      if (wr_cmp1) cmp1 <= reg_wdata_i;
      if (wr_cmp2) cmp2 <= reg_wdata_i;

      if (hit1)         cflag[0] <= 1'b1;
      else if (wr_cmp1) cflag[0] <= 1'b0;
      if (hit2)         cflag[1] <= 1'b1;
      else if (wr_cmp2) cflag[1] <= 1'b0;

      if (hit1) oc1_q <= aux[1];
      if (hit2) oc2_q <= aux[2];

      if (!opm_on)                  os_active <= 1'b0;
      else if (trig)                os_active <= 1'b1;
      else if (os_active && hit1)   os_active <= 1'b0;
    end
  end

  logic pin1_lvl;
  always_comb begin
    if (pwm_on)      pin1_lvl = (cnt < cmp1) ? aux[1] : aux[2];
    else if (opm_on) pin1_lvl = os_active ? aux[1] : aux[2];
    else             pin1_lvl = oc1_q;
  end

  assign oc1_o      = ctrl.pin1_en & pin1_lvl;
  assign oc2_o      = ctrl.pin2_en & oc2_q;
  assign cmp_flag_o = cflag;
  assign cap_flag_o = cap_flag;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o[CW-1:0] = ctrl;
      A_CMP1:  reg_rdata_o = cmp1;
      A_CMP2:  reg_rdata_o = cmp2;
      A_CAP1:  reg_rdata_o = cap_val[0];
      A_CAP2:  reg_rdata_o = cap_val[1];
      A_CNT:   reg_rdata_o = cnt;
      A_AUX:   reg_rdata_o[AW-1:0] = aux;
      default: reg_rdata_o = '0;
    endcase
  end

  // ---------------- assertions ----------------
  assert_ext_absent_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_EXT_CLK && ctrl.clk_sel == CK_EXT && !trig) |=> $stable(cnt));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !pwm_on) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  assert_pwm_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_on && tick && cnt >= cmp2) |=> (cnt == '0));

  assert_pulse_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(os_active) |-> ($past(trig) && cnt == '0));

  assert_pin_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.pin1_en && !ctrl.pin2_en) |-> (!oc1_o && !oc2_o));

endmodule

// File: tb/ctimer_top_bench.sv
`timescale 1ns/1ps
module ctimer_top_bench;
  import ctimer_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0, cap1 = 1'b0, cap2 = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, rdata_n;
  logic        oc1, oc2, oc1_n, oc2_n;
  logic [1:0]  cmpf, capf, cmpf_n, capf_n;

  always #2 clk = ~clk;   // 250 MHz

  ctimer_top u_ctimer_top (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .cap1_i(cap1), .cap2_i(cap2),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .oc1_o(oc1), .oc2_o(oc2), .cmp_flag_o(cmpf), .cap_flag_o(capf)
  );

  ctimer_top #(.HAS_EXT_CLK(1'b0)) u_noext (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .cap1_i(cap1), .cap2_i(cap2),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_n), .oc1_o(oc1_n), .oc2_o(oc2_n), .cmp_flag_o(cmpf_n), .cap_flag_o(capf_n)
  );

  int n_run = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] pa, pn;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read data whenever a checked read is on the port
  always @(negedge clk) begin
    if (rd) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 16'h1, 16'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1; step(); wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    addr = a; rd = 1'b1; step(); rd = 1'b0;
  endtask

  task automatic peek_cnt();
    addr = A_CNT; @(negedge clk); pa = rdata; pn = rdata_n; step();
  endtask

  task automatic hold(input int n);
    repeat (n) step();
  endtask

  task automatic ext_half(input logic v);
    ext_clk = v; hold(4);
  endtask

  task automatic ext_pulse();
    ext_half(1'b1); ext_half(1'b0);
  endtask

  task automatic rate_check(input logic [15:0] ctl, input int div, input string tag);
    logic [15:0] a0;
    wr_reg(A_CTRL, ctl);
    peek_cnt(); a0 = pa;
    hold(79);
    peek_cnt();
    check(tag, pa - a0, 16'(80 / div));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] c0, k;
    hold(5);
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 pins", {14'd0, oc1, oc2}, 16'd0);
    check("R1 flags", {12'd0, cmpf, capf}, 16'd0);
    rd_expect(A_CTRL, 16'h0, "R1 control");
    rd_expect(A_AUX, 16'h0, "R1 aux");
    rd_expect(A_CAP1, 16'h0, "R1 capture1");
    rd_expect(A_CMP2, 16'h0, "R1 compare2");

    // R2 divided rates
    rate_check(16'h00, 4, "R2 div4");
    rate_check(16'h04, 2, "R2 div2");
    rate_check(16'h08, 8, "R2 div8");

    // R3 external clock edges, R4 absent pin freezes
    wr_reg(A_CTRL, 16'h0D);
    peek_cnt(); c0 = pa; k = pn;
    ext_half(1'b1); peek_cnt(); check("R3 rising counted", pa, c0 + 16'd1);
    ext_half(1'b0); peek_cnt(); check("R3 falling ignored", pa, c0 + 16'd1);
    wr_reg(A_CTRL, 16'h0C);
    ext_half(1'b1); peek_cnt(); check("R3 rising ignored", pa, c0 + 16'd1);
    ext_half(1'b0); peek_cnt(); check("R3 falling counted", pa, c0 + 16'd2);
    check("R4 no ext pin frozen", pn, k);
    // R12 read-only counter ignores writes
    wr_reg(A_CNT, 16'h1234);
    peek_cnt(); check("R12 counter write ignored", pa, c0 + 16'd2);
    c0 = pa;

    // R5/R6 capture
    wr_reg(A_CTRL, 16'h0E);
    cap2 = 1'b1; hold(4);
    check("R5 cap2 flag", {15'd0, capf[1]}, 16'd1);
    rd_expect(A_CAP2, c0, "R5 cap2 value");
    check("R6 read clears cap2 flag", {15'd0, capf[1]}, 16'd0);
    cap2 = 1'b0; hold(4);
    check("R5 cap2 falling ignored", {15'd0, capf[1]}, 16'd0);
    cap1 = 1'b1; hold(4);
    check("R5 cap1 rising ignored", {15'd0, capf[0]}, 16'd0);
    ext_pulse();
    cap1 = 1'b0; hold(4);
    check("R5 cap1 flag", {15'd0, capf[0]}, 16'd1);
    rd_expect(A_CAP1, c0 + 16'd1, "R5 cap1 value");
    check("R6 read clears cap1 flag", {15'd0, capf[0]}, 16'd0);

    // R7/R8 output compare
    k = c0 + 16'd1;
    wr_reg(A_CMP1, k + 16'd2);
    wr_reg(A_CMP2, k + 16'd1);
    wr_reg(A_AUX, 16'h6);
    wr_reg(A_CTRL, 16'h8C);
    ext_pulse();
    check("R8 flag2 with pin disabled", {15'd0, cmpf[1]}, 16'd1);
    check("R8 disabled pin2 low", {15'd0, oc2}, 16'd0);
    check("R7 pin1 before match", {15'd0, oc1}, 16'd0);
    ext_pulse();
    check("R7 flag1", {15'd0, cmpf[0]}, 16'd1);
    check("R7 pin1 level1", {15'd0, oc1}, 16'd1);
    wr_reg(A_CTRL, 16'hCC);
    check("R8 pin2 shows latched level", {15'd0, oc2}, 16'd1);
    wr_reg(A_CMP1, 16'h7FFF);
    check("R7 write clears flag1", {15'd0, cmpf[0]}, 16'd0);

    // R9 PWM
    wr_reg(A_AUX, 16'h2);
    wr_reg(A_CMP1, 16'd2);
    wr_reg(A_CMP2, 16'd5);
    wr_reg(A_CTRL, 16'h9C);
    for (int i = 0; i < 8; i++) begin
      peek_cnt();
      if (pa == 16'd0) break;
      ext_pulse();
    end
    check("R9 reached reload", pa, 16'd0);
    for (int j = 1; j <= 12; j++) begin
      ext_pulse();
      check("R9 pwm level", {15'd0, oc1}, ((j % 6) < 2) ? 16'd1 : 16'd0);
      if (j % 4 == 0) begin
        peek_cnt(); check("R9 pwm count", pa, 16'(j % 6));
      end
    end
    // PWM wins over single-pulse: trigger edge does not reset the counter
    wr_reg(A_AUX, 16'h3);
    wr_reg(A_CTRL, 16'hBC);
    cap1 = 1'b1; hold(4);
    peek_cnt(); check("R9 pwm priority", pa, 16'd0);
    ext_pulse(); ext_pulse();
    peek_cnt(); check("R9 pwm priority count", pa, 16'd2);
    cap1 = 1'b0; hold(4);

    // R10/R11 single pulse
    wr_reg(A_CMP1, 16'd3);
    wr_reg(A_CTRL, 16'hAC);
    check("R10 idle level2", {15'd0, oc1}, 16'd0);
    cap1 = 1'b1; hold(4);
    peek_cnt(); check("R10 trigger resets counter", pa, 16'd0);
    check("R10 pulse level1", {15'd0, oc1}, 16'd1);
    ext_pulse();
    cap1 = 1'b0; hold(4); cap1 = 1'b1; hold(4);
    peek_cnt(); check("R11 retrigger ignored", pa, 16'd1);
    ext_pulse();
    check("R10 still active", {15'd0, oc1}, 16'd1);
    ext_pulse();
    check("R10 pulse ended", {15'd0, oc1}, 16'd0);
    cap1 = 1'b0; hold(4); cap1 = 1'b1; hold(4);
    check("R10 new pulse", {15'd0, oc1}, 16'd1);
    peek_cnt(); check("R10 new pulse count", pa, 16'd0);

    hold(4);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule